// File: doc/BRIEF.md
# Signed and Fractional 8x8 Multiplier Unit

This unit multiplies two 8-bit operands and treats each one as signed or unsigned according to a two-bit mode. Three combinations are supported: both operands unsigned, both operands signed, and the first signed with the second unsigned. A fractional flag moves the product one place to the left before it is stored, which keeps a fixed-point result aligned with the binary point of the operands.

A request is made by pulsing `start_i` while the unit is idle. Every operation takes exactly two cycles. In the second cycle `done_o` goes high for one cycle, and at that point the 16-bit result is present on a fixed high/low byte output pair, together with updated zero and carry flags. The operands themselves never choose the destination. The result and the flags keep their values until the next operation completes. A request that arrives while the unit is busy is dropped, and the operation already running finishes without change.

Top module: `fxmul_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o`, both result bytes, `flag_z_o` and `flag_c_o` are all 0.
- R2: If `start_i` is sampled high while `busy_o` is low, `busy_o` is high for exactly the next two cycles. `done_o` is high only in the second of those cycles, and the result and flags are valid in that same cycle.
- R3: A `start_i` sampled while `busy_o` is high, including in the `done_o` cycle, is ignored. It does not lengthen the busy period and does not change the result of the running operation.
- R4: `mode_i` = 2'b00 multiplies both operands as unsigned. The reserved code 2'b11 behaves the same way.
- R5: `mode_i` = 2'b01 multiplies both operands as two's-complement signed values.
- R6: `mode_i` = 2'b10 sign-extends operand A and zero-extends operand B before multiplying.
- R7: When `frac_i` is high at the request, the stored result is the 16-bit product shifted left by one bit. The old bit 15 is discarded and bit 0 becomes 0.
- R8: `flag_c_o` takes bit 15 of the product before any fractional shift.
- R9: `flag_z_o` is 1 exactly when the stored 16-bit result, after any shift, is zero.
- R10: The result bytes and flags change only in the `done_o` cycle and hold their values at all other times, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a multiply; sampled only when idle |
| mode_i | input | 2 | Signedness select: 00 unsigned, 01 signed, 10 signed A by unsigned B, 11 as 00 |
| frac_i | input | 1 | Shift the stored product left by one |
| opa_i | input | 8 | Operand A |
| opb_i | input | 8 | Operand B |
| busy_o | output | 1 | High during the two cycles of an operation |
| done_o | output | 1 | One-cycle pulse in the second cycle; result valid |
| res_hi_o | output | 8 | High byte of the stored result |
| res_lo_o | output | 8 | Low byte of the stored result |
| flag_z_o | output | 1 | Stored result is zero |
| flag_c_o | output | 1 | Bit 15 of the unshifted product |

## Verification
Completion of an operation and a new request can land in the same cycle. A request raised in the `done_o` cycle meets a unit that is still busy, so it must be dropped, and `busy_o` must fall on the next cycle. The bench holds `start_i` high with different operands through both busy cycles, including the completion cycle. It then checks that the stored result and flags belong to the first operation and that the unit is idle one cycle after `done_o`.

// File: rtl/fxmul_pkg.sv
package fxmul_pkg;

  typedef enum logic [1:0] {
    MODE_UU  = 2'b00,
    MODE_SS  = 2'b01,
    MODE_SU  = 2'b10,
    MODE_RSV = 2'b11
  } mul_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PART = 2'b01,
    ST_SUM  = 2'b10
  } mul_state_e;

  function automatic logic a_is_signed(input logic [1:0] m);
    return (m == MODE_SS) || (m == MODE_SU);
  endfunction

  function automatic logic b_is_signed(input logic [1:0] m);
    return (m == MODE_SS);
  endfunction

endpackage

// File: rtl/fxmul_ext.sv
module fxmul_ext #(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic         sgn_i,
  output logic [W:0]   ext_o
);
  // One extra top bit; it copies the sign only for signed operands.
  assign ext_o = {sgn_i & val_i[W-1], val_i};
endmodule

// File: rtl/fxmul_ctrl.sv
module fxmul_ctrl
  import fxmul_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic advance_o,
  output logic busy_o,
  output logic done_o
);

  mul_state_e state_q, state_d;

  assign accept_o  = start_i && (state_q == ST_IDLE);
  assign advance_o = (state_q == ST_PART);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_SUM);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_PART;
      ST_PART: state_d = ST_SUM;
      ST_SUM:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !done_o));
  assert_second_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> done_o);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);
  assert_late_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> !busy_o);

endmodule

// File: rtl/fxmul_core.sv
module fxmul_core #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           finish_i,
  input  logic [W:0]     a_ext_i,
  input  logic [W:0]     b_ext_i,
  input  logic           frac_i,
  output logic [2*W-1:0] res_o,
  output logic           z_o,
  output logic           c_o
);

  localparam int XW = W + 1;
  localparam int LW = W / 2;
  localparam int HW = XW - LW;
  localparam int PW = 2 * W;
  localparam int AW = 2 * W + 2;

  function automatic logic [AW-1:0] widen_a(input logic [XW-1:0] v);
    return {{(AW-XW){v[XW-1]}}, v};
  endfunction

  // Low slice of B is always unsigned.
  function automatic logic [AW-1:0] part_low(input logic [XW-1:0] a, input logic [XW-1:0] b);
    logic [AW-1:0] bl;
    bl = {{(AW-LW){1'b0}}, b[LW-1:0]};
    return widen_a(a) * bl;
  endfunction

  // High slice of B carries the sign of the extended operand.
  function automatic logic [AW-1:0] part_high(input logic [XW-1:0] a, input logic [XW-1:0] b);
    logic [AW-1:0] bh;
    bh = {{(AW-HW){b[XW-1]}}, b[XW-1:LW]};
    return widen_a(a) * bh;
  endfunction

  function automatic logic [PW-1:0] merge_parts(input logic [AW-1:0] lo, input logic [AW-1:0] hi);
    logic [AW-1:0] s;
    s = lo + (hi << LW);
    return s[PW-1:0];
  endfunction

  function automatic logic [PW-1:0] frac_align(input logic [PW-1:0] p, input logic f);
    return f ? {p[PW-2:0], 1'b0} : p;
  endfunction

  logic [AW-1:0] pp_lo_q, pp_hi_q;
  logic          frac_q;
  logic [PW-1:0] raw_prod;
  logic [PW-1:0] stored_val;
  logic          carry_evt;
  logic          zero_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pp_lo_q <= '0;
      pp_hi_q <= '0;
      frac_q  <= 1'b0;
    end else if (load_i) begin
      pp_lo_q <= part_low(a_ext_i, b_ext_i);
      pp_hi_q <= part_high(a_ext_i, b_ext_i);
      frac_q  <= frac_i;
    end
  end

  assign raw_prod   = merge_parts(pp_lo_q, pp_hi_q);
  assign stored_val = frac_align(raw_prod, frac_q);
  assign carry_evt  = raw_prod[PW-1];
  assign zero_evt   = (stored_val == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o <= '0;
      z_o   <= 1'b0;
      c_o   <= 1'b0;
    end else if (finish_i) begin
      res_o <= stored_val;
      z_o   <= zero_evt;
      c_o   <= carry_evt;
    end
  end

  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    finish_i |=> (z_o == (res_o == '0)));
  assert_frac_lsb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_i && frac_q) |=> (res_o[0] == 1'b0));
  assert_hold_res_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !finish_i |=> ($stable(res_o) && $stable(z_o) && $stable(c_o)));

endmodule

// File: rtl/fxmul_unit.sv
module fxmul_unit
  import fxmul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   mode_i,
  input  logic         frac_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] res_hi_o,
  output logic [W-1:0] res_lo_o,
  output logic         flag_z_o,
  output logic         flag_c_o
);

  localparam int NOPS = 2;
  localparam int PW   = 2 * W;

  logic accept_w, advance_w;
  logic [W-1:0]   op_raw [NOPS];
  logic           op_sgn [NOPS];
  logic [W:0]     op_ext [NOPS];
  logic [PW-1:0]  res_w;

  assign op_raw[0] = opa_i;
  assign op_raw[1] = opb_i;
  assign op_sgn[0] = a_is_signed(mode_i);
  assign op_sgn[1] = b_is_signed(mode_i);

  for (genvar g = 0; g < NOPS; g++) begin : g_ext
    fxmul_ext #(.W(W)) u_ext (
      .val_i (op_raw[g]),
      .sgn_i (op_sgn[g]),
      .ext_o (op_ext[g])
    );
  end

  fxmul_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .accept_o  (accept_w),
    .advance_o (advance_w),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  fxmul_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept_w),
    .finish_i (advance_w),
    .a_ext_i  (op_ext[0]),
    .b_ext_i  (op_ext[1]),
    .frac_i   (frac_i),
    .res_o    (res_w),
    .z_o      (flag_z_o),
    .c_o      (flag_c_o)
  );

  assign res_hi_o = res_w[PW-1:W];
  assign res_lo_o = res_w[W-1:0];

  assert_update_in_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(res_w)) |-> done_o);

endmodule

// File: tb/tb_fxmul_unit.sv
module tb_fxmul_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic frac_i = 1'b0;
  logic [7:0] opa_i = 8'h00, opb_i = 8'h00;
  logic busy_o, done_o, flag_z_o, flag_c_o;
  logic [7:0] res_hi_o, res_lo_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fxmul_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .frac_i(frac_i),
    .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
    .res_hi_o(res_hi_o), .res_lo_o(res_lo_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  // Reference: integer arithmetic on the values the mode gives the operands.
  task automatic model(input logic [7:0] a, input logic [7:0] b, input logic [1:0] m,
                       input logic fr, output logic [15:0] r, output logic z, output logic c);
    int ia, ib, p;
    logic [15:0] raw;
    bit sa, sb;
    sa = (m == 2'b01) || (m == 2'b10);
    sb = (m == 2'b01);
    ia = (sa && a[7]) ? int'(a) - 256 : int'(a);
    ib = (sb && b[7]) ? int'(b) - 256 : int'(b);
    p = ia * ib;
    raw = p[15:0];
    c = raw[15];
    r = fr ? {raw[14:0], 1'b0} : raw;
    z = (r == 16'h0000);
  endtask

  task automatic do_op(input string req, input logic [7:0] a, input logic [7:0] b,
                       input logic [1:0] m, input logic fr);
    logic [15:0] er;
    logic ez, ec;
    model(a, b, m, fr, er, ez, ec);
    opa_i = a; opb_i = b; mode_i = m; frac_i = fr; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk({req, " R2 busy first cycle"}, {busy_o, done_o}, 2'b10);
    @(negedge clk);
    chk({req, " R2 done second cycle"}, {busy_o, done_o}, 2'b11);
    chk({req, " result"}, {res_hi_o, res_lo_o}, er);
    chk({req, " R9 zero flag"}, flag_z_o, ez);
    chk({req, " R8 carry flag"}, flag_c_o, ec);
    @(negedge clk);
    chk({req, " R2 idle after"}, {busy_o, done_o}, 2'b00);
  endtask

  task automatic t_reset();
    chk("R1 busy/done", {busy_o, done_o}, 2'b00);
    chk("R1 result", {res_hi_o, res_lo_o}, 16'h0000);
    chk("R1 flags", {flag_z_o, flag_c_o}, 2'b00);
  endtask

  task automatic t_unsigned();
    do_op("R4 uu 255x255", 8'hFF, 8'hFF, 2'b00, 1'b0);
    do_op("R4 uu 12x34", 8'd12, 8'd34, 2'b00, 1'b0);
    do_op("R4 reserved mode 200x3", 8'd200, 8'd3, 2'b11, 1'b0);
  endtask

  task automatic t_signed();
    do_op("R5 ss -128x-128", 8'h80, 8'h80, 2'b01, 1'b0);
    do_op("R5 ss -1x5", 8'hFF, 8'h05, 2'b01, 1'b0);
    do_op("R5 ss 127x-128", 8'h7F, 8'h80, 2'b01, 1'b0);
  endtask

  task automatic t_mixed();
    do_op("R6 su -1x255", 8'hFF, 8'hFF, 2'b10, 1'b0);
    do_op("R6 su 100x200", 8'd100, 8'd200, 2'b10, 1'b0);
    do_op("R6 su -128x255", 8'h80, 8'hFF, 2'b10, 1'b0);
  endtask

  task automatic t_fraction();
    do_op("R7 frac ss -128x-128", 8'h80, 8'h80, 2'b01, 1'b1);
    do_op("R7 frac uu 255x255", 8'hFF, 8'hFF, 2'b00, 1'b1);
    do_op("R7 frac su -1x255", 8'hFF, 8'hFF, 2'b10, 1'b1);
    do_op("R8 frac ss 64x-128", 8'h40, 8'h80, 2'b01, 1'b1);
  endtask

  task automatic t_zero();
    do_op("R9 zero uu 0x77", 8'h00, 8'h77, 2'b00, 1'b0);
    do_op("R9 zero frac ss 0x-1", 8'h00, 8'hFF, 2'b01, 1'b1);
  endtask

  task automatic t_hold();
    logic [15:0] er;
    logic ez, ec;
    do_op("R10 prep", 8'hC3, 8'h5A, 2'b00, 1'b0);
    model(8'hC3, 8'h5A, 2'b00, 1'b0, er, ez, ec);
    opa_i = 8'h00; opb_i = 8'h00; mode_i = 2'b01; frac_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 result held", {res_hi_o, res_lo_o}, er);
      chk("R10 flags held", {flag_z_o, flag_c_o}, {ez, ec});
    end
  endtask

  // Start held high through both busy cycles, including the done cycle.
  task automatic t_ignore();
    logic [15:0] er;
    logic ez, ec;
    model(8'd9, 8'd7, 2'b00, 1'b0, er, ez, ec);
    opa_i = 8'd9; opb_i = 8'd7; mode_i = 2'b00; frac_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    opa_i = 8'hFF; opb_i = 8'hFF; mode_i = 2'b01; frac_i = 1'b1;
    chk("R3 busy first cycle", {busy_o, done_o}, 2'b10);
    @(negedge clk);
    opa_i = 8'h80; opb_i = 8'h7F;
    chk("R3 done on time", {busy_o, done_o}, 2'b11);
    chk("R3 first operation result", {res_hi_o, res_lo_o}, er);
    @(negedge clk);
    start_i = 1'b0;
    chk("R3 start in done cycle ignored", {busy_o, done_o}, 2'b00);
    chk("R3 result unchanged", {res_hi_o, res_lo_o}, er);
    chk("R3 flags unchanged", {flag_z_o, flag_c_o}, {ez, ec});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unsigned();
    t_signed();
    t_mixed();
    t_fraction();
    t_zero();
    t_hold();
    t_ignore();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule